// File: doc/BRIEF.md
# Float to Half-Precision Narrowing Converter

This block narrows one IEEE 754 binary floating-point word to the 16-bit half format. By default the input is single precision; setting the `IN_DOUBLE` parameter makes the input double precision, and the conversion rules stay the same. The input word is split into sign, exponent and significand. The value is then sorted into one of five cases: zero or wide subnormal, infinity or NaN, overflow, the half-subnormal range, or normal. The half word is built from whichever case applies.

Precision is reduced by truncation: bits below the kept significand bits are dropped without rounding. Wide-format subnormals become signed zero. A NaN keeps its low ten significand bits as its payload, and gets the quiet bit instead when those ten bits are all zero. The conversion logic is combinational and feeds one register stage. A valid strobe travels alongside the data through that stage.

Top module: `fp_narrow_half`

## Requirements
- R1: For a normal in-range input (unbiased exponent e from -14 to 15), the output exponent field [14:10] is e+15 and the significand field [9:0] is the top ten input significand bits. Lower bits are discarded with no rounding.
- R2: Output bit 15 always equals the input sign bit (the input MSB).
- R3: An input with a biased exponent of zero (zero or a wide subnormal) produces output bits [14:0] equal to zero.
- R4: An unbiased exponent above 15 (not all-ones) produces signed infinity: exponent field 0x1F and significand field 0.
- R5: An all-ones input exponent with a zero significand produces signed infinity (bits [14:0] = 0x7C00).
- R6: An all-ones input exponent with a nonzero significand produces exponent field 0x1F. The significand field is the low ten input significand bits, or 0x200 if those ten bits are zero.
- R7: An unbiased exponent below -14 gives exponent field 0. The significand field is the input significand with its hidden 1 restored, shifted right by (-14 - e) + (input significand width - 10).
- R8: In the R7 path, a shift count at or beyond the restored significand width (24 for single input, 53 for double) gives a significand field of 0.
- R9: `out_vld` equals `in_vld` delayed by exactly one clock. Reset (asynchronous, active low) clears `out_vld`.
- R10: `out_half` loads only on a clock where `in_vld` is high, and otherwise keeps its value. Reset clears it to 0.
- R11: With `IN_DOUBLE` = 1, a 64-bit input (11-bit exponent, bias 1023, 52-bit significand) is converted under the same rules R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 32 (64 if IN_DOUBLE) | Wide floating-point input word |
| out_vld | output | 1 | Registered valid, one cycle after `in_vld` |
| out_half | output | 16 | Registered half-precision result |

## Verification
The conversion is tried with values from every class, and each pattern separates neighbouring cases:
- Exact normals and values with dropped low bits separate truncation from rounding; 65504 and 65520 both give 0x7BFF, where rounding would give infinity for the second.
- Exponents just above and just below the limits (2^15 against 2^16, and 2^-14 against 2^-15) expose off-by-one errors in the case boundaries.
- 2^-24 and 2^-25 sit on either side of the shift cut-off.
- NaNs with and without low payload bits separate payload keeping from quiet-bit substitution.
- Signed zeros and wide subnormals confirm the flush to zero.
- A second, double-input instance repeats the key boundaries with the 42-bit width difference.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int HALF_MAN = 10;
  localparam int HALF_EXP = 5;
  localparam int HALF_W   = 16;

  localparam logic [HALF_EXP-1:0] HALF_EXP_TOP = 5'h1F;
  localparam logic [HALF_MAN-1:0] HALF_QUIET   = 10'h200;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SPECIAL,
    CL_OVF,
    CL_SUB,
    CL_NORM
  } fpn_class_e;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0] exp_b,
  input  logic [MAN_W-1:0] man,
  output fpn_class_e       cls,
  output logic             man_nz
);

  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OVF_HI = BIAS + 15;
  localparam int SUB_LO = BIAS - 14;

  always_comb begin
    man_nz = |man;
    if (&exp_b)                          cls = CL_SPECIAL;
    else if (exp_b == '0)                cls = CL_ZERO;
    else if (exp_b > EXP_W'(OVF_HI))     cls = CL_OVF;
    else if (exp_b < EXP_W'(SUB_LO))     cls = CL_SUB;
    else                                 cls = CL_NORM;
  end

endmodule

// File: rtl/fpn_assemble.sv
module fpn_assemble
  import fpn_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  fpn_class_e           cls,
  input  logic                 man_nz,
  input  logic                 sign,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic [MAN_W-1:0]     man,
  output logic [HALF_W-1:0]    half
);

  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SUB_LO = BIAS - 14;
  localparam int REBIAS = BIAS - 15;
  localparam int WDIFF  = MAN_W - HALF_MAN;
  localparam int RST_W  = MAN_W + 1;
  localparam int SH_W   = EXP_W + 2;

  logic [RST_W-1:0]    restored;
  logic [SH_W-1:0]     shamt;
  logic [HALF_EXP-1:0] h_exp;
  logic [HALF_MAN-1:0] h_man;
  logic [HALF_MAN-1:0] nan_low;

  always_comb begin
    restored = {1'b1, man};
    shamt    = SH_W'(SUB_LO) - SH_W'(exp_b) + SH_W'(WDIFF);
    nan_low  = man[HALF_MAN-1:0];
    h_exp    = '0;
    h_man    = '0;
    unique case (cls)
      CL_SPECIAL: begin
        h_exp = HALF_EXP_TOP;
        if (man_nz) h_man = (nan_low == '0) ? HALF_QUIET : nan_low;
      end
      CL_OVF: begin
        h_exp = HALF_EXP_TOP;
      end
      CL_SUB: begin
        if (shamt < SH_W'(RST_W)) h_man = HALF_MAN'(restored >> shamt);
      end
      CL_NORM: begin
        h_exp = HALF_EXP'(exp_b - EXP_W'(REBIAS));
        h_man = man[MAN_W-1 -: HALF_MAN];
      end
      default: begin
        h_exp = '0;
        h_man = '0;
      end
    endcase
    half = {sign, h_exp, h_man};
  end

endmodule

// File: rtl/fp_narrow_half.sv
module fp_narrow_half
  import fpn_pkg::*;
#(
  parameter bit IN_DOUBLE = 1'b0,
  localparam int EXP_W = IN_DOUBLE ? 11 : 8,
  localparam int MAN_W = IN_DOUBLE ? 52 : 23,
  localparam int IN_W  = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IN_W-1:0]   in_word,
  output logic              out_vld,
  output logic [HALF_W-1:0] out_half
);

  logic              sign;
  logic [EXP_W-1:0]  exp_b;
  logic [MAN_W-1:0]  man;
  fpn_class_e        cls;
  logic              man_nz;
  logic [HALF_W-1:0] conv;

  logic              vld_nx;
  logic [HALF_W-1:0] half_nx;

  assign sign  = in_word[IN_W-1];
  assign exp_b = in_word[IN_W-2 -: EXP_W];
  assign man   = in_word[MAN_W-1:0];

  fpn_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .exp_b  (exp_b),
    .man    (man),
    .cls    (cls),
    .man_nz (man_nz)
  );

  fpn_assemble #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_asm (
    .cls    (cls),
    .man_nz (man_nz),
    .sign   (sign),
    .exp_b  (exp_b),
    .man    (man),
    .half   (conv)
  );

  always_comb begin
    vld_nx  = in_vld;
    half_nx = out_half;
    if (in_vld) half_nx = conv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_half <= '0;
    end else begin
      out_vld  <= vld_nx;
      out_half <= half_nx;
    end
  end

endmodule

// File: rtl/fpn_checker.sv
module fpn_checker #(
  parameter bit IN_DOUBLE = 1'b0,
  localparam int EXP_W = IN_DOUBLE ? 11 : 8,
  localparam int MAN_W = IN_DOUBLE ? 52 : 23,
  localparam int IN_W  = 1 + EXP_W + MAN_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [IN_W-1:0] in_word,
  input logic            out_vld,
  input logic [15:0]     out_half
);

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  assign ex = in_word[IN_W-2 -: EXP_W];
  assign mn = in_word[MAN_W-1:0];

  p_vld_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_half));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_half[15] == $past(in_word[IN_W-1])));

  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ex == '0) |=> (out_half[14:0] == 15'h0));

  p_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !(&ex) && ex > EXP_W'(BIAS + 15)) |=> (out_half[14:0] == 15'h7C00));

  p_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (&ex) && mn == '0) |=> (out_half[14:0] == 15'h7C00));

  p_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (&ex) && mn != '0) |=> (out_half[14:10] == 5'h1F && out_half[9:0] != 10'h0));

endmodule

bind fp_narrow_half fpn_checker #(.IN_DOUBLE(IN_DOUBLE)) u_fpn_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_word  (in_word),
  .out_vld  (out_vld),
  .out_half (out_half)
);

// File: tb/fp_narrow_half_test.sv
`timescale 1ns/1ps
module fp_narrow_half_test;

  logic        clk;
  logic        rst_n;
  logic        in_vld, in_vld_d;
  logic [31:0] in_word;
  logic [63:0] in_word_d;
  logic        out_vld, out_vld_d;
  logic [15:0] out_half, out_half_d;

  int n_chk;
  int n_fail;

  fp_narrow_half #(.IN_DOUBLE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .out_vld(out_vld), .out_half(out_half)
  );

  fp_narrow_half #(.IN_DOUBLE(1'b1)) uut_dbl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld_d), .in_word(in_word_d),
    .out_vld(out_vld_d), .out_half(out_half_d)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {requirement number, single input, expected half}
  localparam int NV = 24;
  localparam logic [55:0] VEC [NV] = '{
    {8'd1,  32'h3F800000, 16'h3C00},  // R1 1.0
    {8'd2,  32'hC0200000, 16'hC100},  // R2 -2.5
    {8'd1,  32'h477FE000, 16'h7BFF},  // R1 65504
    {8'd1,  32'h477FF000, 16'h7BFF},  // R1 65520 truncated, not rounded
    {8'd1,  32'h3F801FFF, 16'h3C00},  // R1 dropped low bits
    {8'd1,  32'h3FFFFFFF, 16'h3FFF},  // R1 all kept bits set
    {8'd1,  32'h38800000, 16'h0400},  // R1 smallest half normal
    {8'd4,  32'h47800000, 16'h7C00},  // R4 2^16
    {8'd4,  32'hFE000000, 16'hFC00},  // R4 large negative
    {8'd5,  32'h7F800000, 16'h7C00},  // R5 +inf
    {8'd5,  32'hFF800000, 16'hFC00},  // R5 -inf
    {8'd6,  32'h7FC00000, 16'h7E00},  // R6 quiet bit substituted
    {8'd6,  32'h7F8003FF, 16'h7FFF},  // R6 payload kept
    {8'd6,  32'hFF800155, 16'hFD55},  // R6 negative payload
    {8'd3,  32'h00000000, 16'h0000},  // R3 +0
    {8'd3,  32'h80000000, 16'h8000},  // R3 -0
    {8'd3,  32'h00000001, 16'h0000},  // R3 tiny subnormal
    {8'd3,  32'h807FFFFF, 16'h8000},  // R3 largest subnormal
    {8'd7,  32'h38000000, 16'h0200},  // R7 2^-15
    {8'd7,  32'h387FFFFF, 16'h03FF},  // R7 truncated subnormal
    {8'd7,  32'hB3800000, 16'h8001},  // R7 -2^-24
    {8'd8,  32'h33000000, 16'h0000},  // R8 2^-25 shift equals width
    {8'd8,  32'h00800000, 16'h0000},  // R8 smallest single normal
    {8'd8,  32'h0D000000, 16'h0000}   // R8 far below range
  };

  localparam int ND = 6;
  localparam logic [79:0] VEC_D [ND] = '{
    {64'h3FF0000000000000, 16'h3C00},  // R11 1.0
    {64'h40EFFE0000000000, 16'h7BFF},  // R11 65520 truncated
    {64'h40F0000000000000, 16'h7C00},  // R11 overflow
    {64'h7FF8000000000000, 16'h7E00},  // R11 NaN quiet bit
    {64'h3E70000000000000, 16'h0001},  // R11 2^-24
    {64'hBE60000000000000, 16'h8000}   // R11 2^-25 flushed, sign kept
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [15:0] last;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    in_vld = 1'b0;
    in_vld_d = 1'b0;
    in_word = '0;
    in_word_d = '0;
    repeat (3) @(negedge clk);
    check("R9 reset vld", {15'h0, out_vld}, 16'h0);
    check("R10 reset data", out_half, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_vld = 1'b1;
      in_word = VEC[i][47:16];
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VEC[i][55:48], i), out_half, VEC[i][15:0]);
      check("R9 vld follows", {15'h0, out_vld}, 16'h1);
    end

    // R10: idle input must not disturb held data
    last = out_half;
    in_vld = 1'b0;
    in_word = 32'h7F800000;
    @(negedge clk);
    check("R9 vld drops", {15'h0, out_vld}, 16'h0);
    check("R10 hold", out_half, last);
    @(negedge clk);
    check("R10 hold second cycle", out_half, last);

    // R9: back-to-back words each appear one cycle later
    in_vld = 1'b1;
    in_word = 32'h3F800000;
    @(negedge clk);
    in_word = 32'hC0200000;
    check("R9 back-to-back first", out_half, 16'h3C00);
    @(negedge clk);
    in_vld = 1'b0;
    check("R9 back-to-back second", out_half, 16'hC100);

    // R9 / R10: asynchronous reset mid-stream
    in_vld = 1'b1;
    in_word = 32'h47800000;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset vld", {15'h0, out_vld}, 16'h0);
    check("R10 async reset data", out_half, 16'h0000);
    @(negedge clk);
    in_vld = 1'b0;
    rst_n = 1'b1;

    // R11: double-input instance
    for (int j = 0; j < ND; j++) begin
      @(negedge clk);
      in_vld_d = 1'b1;
      in_word_d = VEC_D[j][79:16];
      @(negedge clk);
      check($sformatf("R11 dbl vec %0d", j), out_half_d, VEC_D[j][15:0]);
      check("R11 dbl vld", {15'h0, out_vld_d}, 16'h1);
    end
    in_vld_d = 1'b0;
    @(negedge clk);
    report();
  end

endmodule